// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the address for each beat of a four-beat memory burst. When a burst starts, a load strobe captures an external address. The block then produces the three follow-on addresses itself, one for each clock edge on which the active-low advance input is asserted. Only the two lowest address bits move during a burst. The upper bits stay at the value captured at load.

Two beat orderings are available, and the order input picks one of them when the load happens.

- **Interleaved order** (order input high): each beat's low bits equal the starting offset XORed with the beat number.
- **Linear order** (order input low): the low bits count up from the starting offset and wrap modulo four.

A memory controller uses the block as follows:

1. It pulses the load strobe with the first address.
2. It holds advance low to step through the burst.
3. It raises advance to suspend the burst for wait cycles. During a suspension the address and the beat index stay where they are.

Top module: `burst_seq_gen`

## Requirements
- R1: While reset is active, and on the first cycle after it, `addr_o` is all zeros and `beat_o` is 0.
- R2: After a clock edge with `load_i` high, `addr_o` equals the `addr_i` presented at that edge and `beat_o` is 0.
- R3: `load_i` takes priority over advance: an edge with `load_i` high and `adv_n_i` low behaves exactly as a load (beat index 0, address equal to `addr_i`).
- R4: With `order_i` = 1 at load, the low two bits of `addr_o` on beat k equal start XOR k. For example, start 2 gives 2,3,0,1 and start 3 gives 3,2,1,0.
- R5: With `order_i` = 0 at load, the low two bits of `addr_o` on beat k equal (start + k) mod 4. For example, start 1 gives 1,2,3,0 and start 3 gives 3,0,1,2.
- R6: On an edge with `load_i` low and `adv_n_i` low, `beat_o` increments by one.
- R7: On an edge with `load_i` low and `adv_n_i` high, `addr_o` and `beat_o` keep their values (a suspend, or wait cycle).
- R8: An advance from beat 3 returns to beat 0, and the address returns to the first address of the same burst.
- R9: The bits of `addr_o` above bit 1 never change except at a load. At a load they take the loaded value.
- R10: `order_i` is sampled only at load. Changing it during a burst has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a burst by capturing `addr_i` |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| order_i | input | 1 | Beat ordering: 1 interleaved, 0 linear; sampled at load |
| addr_i | input | ADDR_W (16) | External start address |
| addr_o | output | ADDR_W (16) | Address of the current beat |
| beat_o | output | OFS_W (2) | Index of the current beat, 0 to 3 |

## Verification
Two functions can act on the same clock edge:

- **Load and advance.** An edge can carry both a load and an advance. The bench provokes this by driving `load_i` high with `adv_n_i` low, both in the middle of a burst and on beat 3. The next cycle must show beat 0 and the freshly loaded address, not a step of the old burst.
- **Step and order change.** A step can coincide with a change on `order_i`. The bench toggles `order_i` on every beat of a burst. The behavioural model, which latched the order at load, must still match `addr_o` on every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Widest offset supported by the arithmetic helpers
  localparam int MAX_OFS_W = 8;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Interleaved beat offset: start xor beat
  function automatic logic [MAX_OFS_W-1:0] ofs_interleave(
    input logic [MAX_OFS_W-1:0] start,
    input logic [MAX_OFS_W-1:0] beat
  );
    return start ^ beat;
  endfunction

  // Linear beat offset: start plus beat, truncated by the caller
  function automatic logic [MAX_OFS_W-1:0] ofs_linear(
    input logic [MAX_OFS_W-1:0] start,
    input logic [MAX_OFS_W-1:0] beat
  );
    return start + beat;
  endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 2,
  localparam int HI_W  = ADDR_W - OFS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  burst_seq_pkg::order_e order_i,
  output logic [HI_W-1:0]      hi_q,
  output logic [OFS_W-1:0]     start_q,
  output burst_seq_pkg::order_e order_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      order_q <= burst_seq_pkg::ORD_INTERLEAVE;
    end else if (load_i) begin
      hi_q    <= addr_i[ADDR_W-1:OFS_W];
      start_q <= addr_i[OFS_W-1:0];
      order_q <= order_i;
    end
  end

endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [OFS_W-1:0] beat_q,
  output logic             wrap_o
);

  localparam logic [OFS_W-1:0] LAST = '1;

  // A step from the final beat rolls over to beat 0
  assign wrap_o = inc_i && !clr_i && (beat_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      beat_q <= '0;
    else if (clr_i)  beat_q <= '0;
    else if (inc_i)  beat_q <= beat_q + 1'b1;
  end

endmodule

// File: rtl/ofs_mapper.sv
module ofs_mapper #(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0]      start_i,
  input  logic [OFS_W-1:0]      beat_i,
  input  burst_seq_pkg::order_e order_i,
  output logic [OFS_W-1:0]      ofs_o
);

  import burst_seq_pkg::*;

  logic [MAX_OFS_W-1:0] start_x, beat_x, il_x, ln_x;

  assign start_x = MAX_OFS_W'(start_i);
  assign beat_x  = MAX_OFS_W'(beat_i);
  assign il_x    = ofs_interleave(start_x, beat_x);
  assign ln_x    = ofs_linear(start_x, beat_x);

  always_comb begin
    if (order_i == ORD_INTERLEAVE) ofs_o = il_x[OFS_W-1:0];
    else                           ofs_o = ln_x[OFS_W-1:0];
  end

endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 2,
  localparam int HI_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_n_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [OFS_W-1:0]  beat_o
);

  import burst_seq_pkg::*;

  // Named events for the checker
  logic load_evt, step_evt, hold_evt, wrap_evt;

  logic [HI_W-1:0]  hi_q;
  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;
  logic [OFS_W-1:0] ofs;
  order_e           order_q;
  order_e           order_in;

  assign order_in = order_e'(order_i);
  assign load_evt = load_i;
  assign step_evt = !load_i && !adv_n_i;
  assign hold_evt = !load_i && adv_n_i;

  burst_base_reg #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_evt),
    .addr_i  (addr_i),
    .order_i (order_in),
    .hi_q    (hi_q),
    .start_q (start_q),
    .order_q (order_q)
  );

  beat_counter #(.OFS_W(OFS_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (load_evt),
    .inc_i  (step_evt),
    .beat_q (beat_q),
    .wrap_o (wrap_evt)
  );

  ofs_mapper #(.OFS_W(OFS_W)) u_map (
    .start_i (start_q),
    .beat_i  (beat_q),
    .order_i (order_q),
    .ofs_o   (ofs)
  );

  assign addr_o = {hi_q, ofs};
  assign beat_o = beat_q;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_evt,
  input logic              step_evt,
  input logic              hold_evt,
  input logic              wrap_evt,
  input logic              order_il,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [OFS_W-1:0]  beat_o
);

  logic [OFS_W-1:0] lo, xr, df;
  assign lo = addr_o[OFS_W-1:0];
  assign xr = lo ^ beat_o;
  assign df = OFS_W'(lo - beat_o);

  // R2 R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (addr_o == $past(addr_i)) && (beat_o == '0));

  // R6
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> beat_o == OFS_W'($past(beat_o) + 1'b1));

  // R7
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> $stable(addr_o) && $stable(beat_o));

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> beat_o == '0);

  // R9
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> addr_o[ADDR_W-1:OFS_W] == $past(addr_o[ADDR_W-1:OFS_W]));

  // R4 R10
  interleave_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && order_il) |=> xr == $past(xr));

  // R5 R10
  linear_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !order_il) |=> df == $past(df));

endmodule

bind burst_seq_gen burst_seq_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_evt (load_evt),
  .step_evt (step_evt),
  .hold_evt (hold_evt),
  .wrap_evt (wrap_evt),
  .order_il (order_q == burst_seq_pkg::ORD_INTERLEAVE),
  .addr_i   (addr_i),
  .addr_o   (addr_o),
  .beat_o   (beat_o)
);

// File: tb/sim_burst_seq_gen.sv
module sim_burst_seq_gen;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic          adv_n_i = 1'b1;
  logic          order_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference state
  int m_hi = 0, m_start = 0, m_beat = 0;
  bit m_il = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq_gen #(.ADDR_W(AW), .OFS_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_n_i(adv_n_i),
    .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  function automatic int exp_addr();
    int lo;
    if (m_il) lo = m_start ^ m_beat;
    else      lo = (m_start + m_beat) % 4;
    return m_hi * 4 + lo;
  endfunction

  task automatic check(input string tag);
    int ea;
    ea = exp_addr();
    n_run++;
    if (int'(addr_o) != ea || int'(beat_o) != m_beat) begin
      n_fail++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, addr_o, beat_o, ea[AW-1:0], m_beat);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare shortly after
  task automatic cyc(input bit ld, input bit adv_n, input bit ord,
                     input int a, input string tag);
    @(negedge clk);
    load_i = ld; adv_n_i = adv_n; order_i = ord; addr_i = a[AW-1:0];
    @(posedge clk);
    if (ld) begin
      m_hi = a / 4; m_start = a % 4; m_beat = 0; m_il = ord;
    end else if (!adv_n) begin
      m_beat = (m_beat + 1) % 4;
    end
    #1;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD * 2 + 1);
    check("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b0, 1'b1, 1'b1, 0, "R1 after reset");

    // R4: every start in interleaved order, six steps to cover the wrap
    for (int s = 0; s < 4; s++) begin
      cyc(1'b1, 1'b1, 1'b1, 16'h1230 + s, "R2 load interleave");
      for (int k = 0; k < 6; k++) cyc(1'b0, 1'b0, 1'b1, 0, "R4 R6 R8 interleave step");
    end

    // R5: every start in linear order
    for (int s = 0; s < 4; s++) begin
      cyc(1'b1, 1'b1, 1'b0, 16'hA5C0 + s, "R2 load linear");
      for (int k = 0; k < 6; k++) cyc(1'b0, 1'b0, 1'b0, 0, "R5 R6 R8 linear step");
    end

    // R7: suspends interleaved with steps, addr_i noise must be ignored
    cyc(1'b1, 1'b1, 1'b0, 16'h0F02, "R2 load");
    for (int k = 0; k < 8; k++)
      cyc(1'b0, (k % 3) != 0, 1'b1, 16'hFFFF - k, "R7 R9 suspend/step");

    // R3: load with advance mid-burst and on beat 3
    cyc(1'b1, 1'b1, 1'b1, 16'h4441, "R2 load");
    cyc(1'b0, 1'b0, 1'b1, 0, "R6 step");
    cyc(1'b1, 1'b0, 1'b0, 16'h7773, "R3 load over advance mid-burst");
    cyc(1'b0, 1'b0, 1'b0, 0, "R5 step");
    cyc(1'b0, 1'b0, 1'b0, 0, "R5 step");
    cyc(1'b0, 1'b0, 1'b0, 0, "R5 step to beat 3");
    cyc(1'b1, 1'b0, 1'b1, 16'hBEE2, "R3 load over advance on beat 3");

    // R10: order_i toggles every beat after load
    cyc(1'b1, 1'b1, 1'b0, 16'h3331, "R2 load linear");
    for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, k[0] ? 1'b0 : 1'b1, 0, "R10 order ignored");
    cyc(1'b1, 1'b1, 1'b1, 16'h2222, "R2 load interleave");
    for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, k[0] ? 1'b1 : 1'b0, 0, "R10 order ignored");

    // R9: back-to-back loads change upper bits only at load
    cyc(1'b1, 1'b1, 1'b1, 16'hFFFF, "R9 load upper ones");
    cyc(1'b1, 1'b1, 1'b1, 16'h0000, "R9 load upper zeros");
    cyc(1'b0, 1'b0, 1'b1, 16'hFFFC, "R9 step keeps upper");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule